// File: doc/BRIEF.md
# I2C master bit timing generator

This block paces the serial clock of an I2C bus controller acting as master. It takes one bit-level request at a time: a start condition, a stop condition or a single data bit. It then produces the open-drain drive-low enables for SCL and SDA. It also produces a strobe at the moment SDA is allowed to change, a strobe at the data-valid point, and a completion pulse. A packed timing word sets every interval. All intervals are counted in prescaled units of (prescale+1) kernel clock cycles. The byte sequencer that surrounds this block issues the requests and consumes the sampled bits.

The SCL and SDA lines are sampled through two-stage synchronisers. After the block releases SCL, it does not count the high phase until the synchronised line reads high. A slave that keeps SCL low therefore stretches the clock. Clearing `enable` releases both lines at once, returns the machine to idle and clears every counter.

The machine has six states:
- `ST_IDLE` waits for a request.
- `ST_HOLD` is the data-hold part of the low phase.
- `ST_SETUP` is the setup part of the low phase.
- `ST_RISE` has SCL released and waits for the line to read high.
- `ST_HIGH` counts the SCL high phase.
- `ST_TAIL` is the start-condition hold, with SDA low and SCL high.

The transitions are:
- `ST_IDLE` goes to `ST_HOLD` on a request while SCL is held low.
- `ST_IDLE` goes to `ST_RISE` on a request while SCL is released.
- `ST_HOLD` goes to `ST_SETUP` when its phase ends, and SDA updates.
- `ST_SETUP` goes to `ST_RISE` when its phase ends, and SCL is released.
- `ST_RISE` goes to `ST_HIGH` once SCL is seen high.
- At the end of the high phase, a start request goes from `ST_HIGH` to `ST_TAIL` and pulls SDA low.
- At the end of the high phase, a data request goes from `ST_HIGH` to `ST_IDLE` and pulls SCL low.
- At the end of the high phase, a stop request goes from `ST_HIGH` to `ST_IDLE` and releases SDA.
- `ST_TAIL` goes to `ST_IDLE` when its phase ends and pulls SCL low.
- Any state goes to `ST_IDLE` when `enable` is low.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, with `enable` high, `req_ready` is 1. `scl_drive_low`, `sda_drive_low`, `sda_shift`, `sample_strobe` and `bit_done` are all 0.
- R2: Let P be `timing_word[3:0]` and D be `timing_word[23:20]`. A request accepted while SCL is held low updates `sda_drive_low` exactly (D+1)(P+1) cycles after the accepting edge. `sda_shift` pulses for one cycle together with that update, while SCL is still driven low.
- R3: Let L be `timing_word[11:4]` and S be `timing_word[27:24]`. SCL is released (S+1)(P+1) further cycles later if L < D+S+1. Otherwise it is released (L-D)(P+1) further cycles later. The low phase therefore lasts at least L+1 units, and setup after the SDA change lasts at least S+1 units.
- R4: Let H be `timing_word[19:12]`. The high phase lasts (H+1)(P+1) cycles. It starts only after the synchronised SCL line reads high. Each extra cycle that a slave holds SCL low delays it by one cycle.
- R5: A data request (`req_kind` 0) drives `sda_drive_low` to the inverse of `req_bit`. When its high phase ends, SCL is driven low again. In that same cycle `bit_done` and `sample_strobe` pulse, and `sample_bit` equals the SDA line level.
- R6: A start request (`req_kind` 1) releases SDA during the low phase if SCL was held low. When SCL was released, it skips the low phase. It pulls SDA low after one high phase, then drives SCL low after a second high phase, together with `bit_done`.
- R7: A stop request (`req_kind` 2) drives SDA low during the low phase. It releases SDA after the high phase, together with `bit_done`, and leaves SCL released.
- R8: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the `bit_done` cycle. Request fields changed while busy have no effect.
- R9: While `enable` is low, both drive-low outputs are 0 in that same cycle, `req_ready` is 0, and requests are ignored. After `enable` returns, the block is idle with SCL released and all counters restarted.
- R10: With no stretching, the release of SCL from a held state to the first high-phase cycle takes 3 kernel cycles, which covers the synchroniser latency. From an already released SCL it takes 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases the lines and clears state |
| timing_word | input | 28 | {setup[27:24], data delay[23:20], high[19:12], low[11:4], prescale[3:0]} |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 data bit, 1 start, 2 stop (3 acts as data) |
| req_bit | input | 1 | Data bit value for a data request |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| req_ready | output | 1 | Idle and enabled; a request can be taken |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| sda_shift | output | 1 | One-cycle pulse when SDA takes its new data-phase value |
| sample_strobe | output | 1 | One-cycle pulse at the data-valid point of a data bit |
| sample_bit | output | 1 | Synchronised SDA level captured at the data-valid point |
| bit_done | output | 1 | One-cycle pulse when a request completes |

## Verification
Several properties are checked on every cycle:
- The line release while disabled.
- The idle state right after re-enabling.
- The SDA shift happening only while SCL is driven low.
- Every SCL fall coinciding with a completion pulse.
- Every completion landing in the idle state.
- The data-valid strobe following a cycle with SCL high.

The exact lengths of the hold, setup and high phases under several timing words are shown only by the bench's cycle-by-cycle trace comparison. So are the extra delay from a stretching slave, the differing sequences of start, repeated start and stop, and the immunity to request changes while busy.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SETUP,
        ST_RISE,
        ST_HIGH,
        ST_TAIL
    } bt_state_t;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_START = 2'd1,
        KIND_STOP  = 2'd2
    } bt_kind_t;

endpackage

// File: rtl/bt_line_sync.sv
module bt_line_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic stage1;
        logic stage2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= 1'b1;
                stage2 <= 1'b1;
            end else begin
                stage1 <= d[g];
                stage2 <= stage1;
            end
        end
        assign q[g] = stage2;
    end
endmodule

// File: rtl/bt_phase_count.sv
module bt_phase_count #(
    parameter int PW = 4,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [PW-1:0] prescale,
    input  logic [LW-1:0] limit,
    output logic          done
);
    logic [PW-1:0] pcnt;
    logic [LW-1:0] ucnt;

    assign done = (pcnt == prescale) && (ucnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            ucnt <= '0;
        end else if (clear) begin
            pcnt <= '0;
            ucnt <= '0;
        end else if (pcnt == prescale) begin
            pcnt <= '0;
            ucnt <= ucnt + 1'b1;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int PW = 4,
    parameter int LW = 8,
    parameter int DW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [PW+2*LW+2*DW-1:0]  timing_word,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic                     req_bit,
    input  logic                     scl_in,
    input  logic                     sda_in,
    output logic                     req_ready,
    output logic                     scl_drive_low,
    output logic                     sda_drive_low,
    output logic                     sda_shift,
    output logic                     sample_strobe,
    output logic                     sample_bit,
    output logic                     bit_done
);
    localparam int LO_POS = PW;
    localparam int HI_POS = PW + LW;
    localparam int DD_POS = PW + 2 * LW;
    localparam int SU_POS = PW + 2 * LW + DW;

    logic [PW-1:0] prescale;
    logic [LW-1:0] low_len;
    logic [LW-1:0] high_len;
    logic [DW-1:0] dly_data;
    logic [DW-1:0] dly_setup;

    assign prescale  = timing_word[PW-1:0];
    assign low_len   = timing_word[LO_POS +: LW];
    assign high_len  = timing_word[HI_POS +: LW];
    assign dly_data  = timing_word[DD_POS +: DW];
    assign dly_setup = timing_word[SU_POS +: DW];

    bt_state_t     state_q, state_d;
    bt_kind_t      kind_q;
    logic          bit_q;
    logic          scl_low_q;
    logic          sda_low_q;
    logic          accept;
    logic          ph_done;
    logic          ph_clear;
    logic          sda_target;
    logic [LW-1:0] limit;
    logic [LW-1:0] setup_n;
    logic [LW:0]   low_ext;
    logic [LW:0]   need_ext;
    logic [LW:0]   rest_ext;
    logic [1:0]    line_s;
    logic          scl_s;
    logic          sda_s;

    bt_line_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_in, scl_in}),
        .q     (line_s)
    );
    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    // setup part of the low phase: fill the low time, but never less than setup delay
    always_comb begin
        low_ext  = {1'b0, low_len};
        need_ext = (LW+1)'(dly_data) + (LW+1)'(dly_setup) + 1'b1;
        rest_ext = low_ext - (LW+1)'(dly_data) - 1'b1;
        if (low_ext >= need_ext) setup_n = rest_ext[LW-1:0];
        else                     setup_n = LW'(dly_setup);
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD:         limit = LW'(dly_data);
            ST_SETUP:        limit = setup_n;
            ST_HIGH, ST_TAIL: limit = high_len;
            default:         limit = '0;
        endcase
    end

    assign req_ready     = enable && (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign scl_drive_low = enable && scl_low_q;
    assign sda_drive_low = enable && sda_low_q;

    always_comb begin
        unique case (kind_q)
            KIND_STOP:  sda_target = 1'b1;
            KIND_START: sda_target = 1'b0;
            default:    sda_target = ~bit_q;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)  state_d = scl_low_q ? ST_HOLD : ST_RISE;
            ST_HOLD:  if (ph_done) state_d = ST_SETUP;
            ST_SETUP: if (ph_done) state_d = ST_RISE;
            ST_RISE:  if (scl_s)   state_d = ST_HIGH;
            ST_HIGH:  if (ph_done) state_d = (kind_q == KIND_START) ? ST_TAIL : ST_IDLE;
            ST_TAIL:  if (ph_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign ph_clear = !enable || (state_d != state_q) ||
                      (state_q == ST_IDLE) || (state_q == ST_RISE);

    bt_phase_count #(.PW(PW), .LW(LW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ph_clear),
        .prescale (prescale),
        .limit    (limit),
        .done     (ph_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= ST_IDLE;
        else if (!enable) state_q <= ST_IDLE;
        else              state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q        <= KIND_DATA;
            bit_q         <= 1'b0;
            scl_low_q     <= 1'b0;
            sda_low_q     <= 1'b0;
            sda_shift     <= 1'b0;
            sample_strobe <= 1'b0;
            sample_bit    <= 1'b0;
            bit_done      <= 1'b0;
        end else if (!enable) begin
            scl_low_q     <= 1'b0;
            sda_low_q     <= 1'b0;
            sda_shift     <= 1'b0;
            sample_strobe <= 1'b0;
            bit_done      <= 1'b0;
        end else begin
            sda_shift     <= 1'b0;
            sample_strobe <= 1'b0;
            bit_done      <= 1'b0;
            if (accept) begin
                kind_q <= bt_kind_t'(req_kind);
                bit_q  <= req_bit;
            end
            unique case (state_q)
                ST_HOLD: if (ph_done) begin
                    sda_low_q <= sda_target;
                    sda_shift <= 1'b1;
                end
                ST_SETUP: if (ph_done) scl_low_q <= 1'b0;
                ST_HIGH: if (ph_done) begin
                    if (kind_q == KIND_START) begin
                        sda_low_q <= 1'b1;
                    end else if (kind_q == KIND_STOP) begin
                        sda_low_q <= 1'b0;
                        bit_done  <= 1'b1;
                    end else begin
                        scl_low_q     <= 1'b1;
                        bit_done      <= 1'b1;
                        sample_strobe <= 1'b1;
                        sample_bit    <= sda_s;
                    end
                end
                ST_TAIL: if (ph_done) begin
                    scl_low_q <= 1'b1;
                    bit_done  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic req_ready,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic sda_shift,
    input logic sample_strobe,
    input logic bit_done,
    input logic scl_in
);
    AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!scl_drive_low && !sda_drive_low)); // R9

    AST_IDLE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!enable) && enable) |-> (req_ready && !scl_drive_low)); // R9

    AST_SHIFT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        sda_shift |-> scl_drive_low); // R2

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        bit_done |-> req_ready); // R8

    AST_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $rose(scl_drive_low) |-> bit_done); // R5

    AST_SAMPLE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        sample_strobe |-> ($past(scl_in) && !$past(scl_drive_low))); // R4
endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .req_ready     (req_ready),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .sda_shift     (sda_shift),
    .sample_strobe (sample_strobe),
    .bit_done      (bit_done),
    .scl_in        (scl_in)
);

// File: tb/i2c_bit_timer_test.sv
module i2c_bit_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [27:0] timing_word = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_bit = 1'b0;
    logic        stretch = 1'b0;
    logic        slave_low = 1'b0;
    logic        scl_in, sda_in;
    logic        req_ready, scl_drive_low, sda_drive_low;
    logic        sda_shift, sample_strobe, sample_bit, bit_done;

    int errors = 0;
    int checks = 0;
    int cfg_p, cfg_l, cfg_h, cfg_d, cfg_s;
    bit cur_scl = 1'b0;
    bit cur_sda = 1'b0;

    always #4 clk = ~clk;

    assign scl_in = !(scl_drive_low || stretch);
    assign sda_in = !(sda_drive_low || slave_low);

    i2c_bit_timer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .timing_word   (timing_word),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_bit       (req_bit),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .req_ready     (req_ready),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .sda_shift     (sda_shift),
        .sample_strobe (sample_strobe),
        .sample_bit    (sample_bit),
        .bit_done      (bit_done)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic set_cfg(input int p, input int l, input int h, input int d, input int s);
        cfg_p = p; cfg_l = l; cfg_h = h; cfg_d = d; cfg_s = s;
        timing_word = {4'(s), 4'(d), 8'(h), 8'(l), 4'(p)};
    endtask

    // setup units per R3
    function automatic int setup_units();
        if (cfg_l >= cfg_d + cfg_s + 1) return cfg_l - cfg_d;
        return cfg_s + 1;
    endfunction

    // kind: 0 data, 1 start, 2 stop; k = stretch cycles; slv = slave pulls SDA
    task automatic run_req(input int kind, input bit b, input int k, input bit slv,
                           input bit hold, input string tag);
        int u, hlen, slen, hilen, lowlen, r, a, fin;
        bit held, newlow, mid, fin_sda, e_scl, e_sda;
        u = cfg_p + 1;
        held = cur_scl;
        hilen = (cfg_h + 1) * u;
        if (held) begin
            hlen = (cfg_d + 1) * u;
            slen = setup_units() * u;
            r = k + 3;
        end else begin
            hlen = 0; slen = 0; r = 1;
        end
        lowlen = hlen + slen;
        a = lowlen + r;
        fin = a + hilen + ((kind == 1) ? hilen : 0);
        newlow = (kind == 2) ? 1'b1 : (kind == 1) ? 1'b0 : !b;
        mid = held ? newlow : cur_sda;
        fin_sda = (kind == 1) ? 1'b1 : (kind == 2) ? 1'b0 : newlow;
        @(negedge clk);
        chk({tag, " R8 ready before request"}, int'(req_ready), 1);
        req_valid = 1'b1; req_kind = 2'(kind); req_bit = b; slave_low = slv;
        @(posedge clk);
        for (int t = 0; t <= fin; t++) begin
            @(negedge clk);
            if (t == 0 && !hold) req_valid = 1'b0;
            if (t == 0 && hold) begin
                req_kind = (kind == 2) ? 2'd0 : 2'd2;
                req_bit = !b;
            end
            if (hold && t == fin) req_valid = 1'b0;
            if (held && k > 0 && t == lowlen) stretch = 1'b1;
            if (held && k > 0 && t == lowlen + k) stretch = 1'b0;
            #1;
            e_scl = (t == fin) ? (kind != 2) : (held && t < lowlen);
            if (held && t < hlen)  e_sda = cur_sda;
            else if (t < a + hilen) e_sda = mid;
            else                   e_sda = fin_sda;
            chk($sformatf("%s R3 R4 scl t=%0d", tag, t), int'(scl_drive_low), int'(e_scl));
            chk($sformatf("%s R2 sda t=%0d", tag, t), int'(sda_drive_low), int'(e_sda));
            chk($sformatf("%s R2 shift t=%0d", tag, t), int'(sda_shift), int'(held && t == hlen));
            chk($sformatf("%s R5 done t=%0d", tag, t), int'(bit_done), int'(t == fin));
            chk($sformatf("%s R8 ready t=%0d", tag, t), int'(req_ready), int'(t == fin));
            chk($sformatf("%s R5 strobe t=%0d", tag, t), int'(sample_strobe),
                int'(kind == 0 && t == fin));
            if (kind == 0 && t == fin)
                chk({tag, " R5 sample_bit"}, int'(sample_bit), int'(!(newlow || slv)));
        end
        slave_low = 1'b0;
        cur_scl = (kind != 2);
        cur_sda = fin_sda;
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        set_cfg(1, 4, 3, 1, 2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 scl", int'(scl_drive_low), 0);
        chk("R1 sda", int'(sda_drive_low), 0);
        chk("R1 pulses", int'(sda_shift) + int'(sample_strobe) + int'(bit_done), 0);

        // first configuration: low time dominates setup
        run_req(1, 1'b0, 0, 1'b0, 1'b0, "cfg1 start idle R6 R10");
        run_req(0, 1'b1, 0, 1'b0, 1'b0, "cfg1 data1 R5 R10");
        run_req(0, 1'b0, 0, 1'b0, 1'b0, "cfg1 data0 R5");
        run_req(0, 1'b1, 0, 1'b1, 1'b0, "cfg1 read R5");
        run_req(0, 1'b0, 5, 1'b0, 1'b0, "cfg1 stretch R4");
        run_req(1, 1'b0, 0, 1'b0, 1'b0, "cfg1 restart R6");
        run_req(0, 1'b1, 0, 1'b0, 1'b1, "cfg1 busy hold R8");
        run_req(2, 1'b0, 0, 1'b0, 1'b0, "cfg1 stop R7");

        // second configuration: setup delay dominates, no prescale
        set_cfg(0, 2, 1, 2, 3);
        run_req(1, 1'b0, 0, 1'b0, 1'b0, "cfg2 start R6");
        run_req(0, 1'b0, 0, 1'b0, 1'b0, "cfg2 data0 R3");
        run_req(0, 1'b1, 2, 1'b1, 1'b0, "cfg2 stretch read R4");
        run_req(2, 1'b0, 0, 1'b0, 1'b0, "cfg2 stop R7");

        // third configuration: zero delays, larger prescale
        set_cfg(3, 9, 5, 0, 0);
        run_req(1, 1'b0, 0, 1'b0, 1'b0, "cfg3 start R6");
        run_req(0, 1'b1, 0, 1'b0, 1'b0, "cfg3 data1 R2 R3");
        run_req(2, 1'b0, 0, 1'b0, 1'b0, "cfg3 stop R7");

        // disable in the middle of a bit
        set_cfg(1, 4, 3, 1, 2);
        run_req(1, 1'b0, 0, 1'b0, 1'b0, "cfg1 start before off R6");
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_bit = 1'b0;
        @(posedge clk);
        repeat (2) @(negedge clk);
        enable = 1'b0;
        #1;
        chk("R9 scl released at once", int'(scl_drive_low), 0);
        chk("R9 sda released at once", int'(sda_drive_low), 0);
        chk("R9 ready low while off", int'(req_ready), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R9 request ignored scl", int'(scl_drive_low), 0);
            chk("R9 request ignored done", int'(bit_done), 0);
            chk("R9 ready stays low", int'(req_ready), 0);
        end
        req_valid = 1'b0;
        enable = 1'b1;
        @(negedge clk); #1;
        chk("R9 idle after return", int'(req_ready), 1);
        chk("R9 scl released after return", int'(scl_drive_low), 0);
        cur_scl = 1'b0;
        cur_sda = 1'b0;
        run_req(1, 1'b0, 0, 1'b0, 1'b0, "after off start R9");
        run_req(0, 1'b0, 0, 1'b0, 1'b0, "after off data R9");
        run_req(2, 1'b0, 0, 1'b0, 1'b0, "after off stop R9");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule